// File: doc/BRIEF.md
# Sample Clock Phase Shift Controller

This block lets software move a generated sample clock earlier or later by a programmed number of small, fixed phase steps. Software writes a 16-bit control word that carries an 8-bit step count and a direction flag. A free-running prescaler divides the master clock by eight. On each prescaler tick, one step is taken from the count while the count is nonzero. Each step becomes a single one-cycle pulse on either the advance output or the retard output, and the clock generator acts on it. Each step is worth 0.12 degrees of the sample clock.

A new write can arrive before the previous count has drained. It replaces whatever is left at once. The count still to be processed is copied into a readback register at each frame-start marker. Software therefore sees a snapshot that is steady for the whole frame. The register and its snapshot are held at zero, and writes are refused, whenever the reset input is low, the power-down input is low, or the generator-enable input is low.

Top module: `phase_shift_ctrl`

## Requirements
- R1: After the reset input goes low, `rdData` reads 0x0000 and neither step output pulses.
- R2: A write loads the step count from `wrData[7:0]` and the direction from `wrData[15]`. Bits 14:8 are discarded and read back as zero, so a snapshot reads {direction, 7'b0, count}.
- R3: A prescaler tick occurs on every eighth clock edge after reset is released. On a tick with a nonzero count, the count drops by one and exactly one pulse appears in the following cycle. The pulse is on `advPulse` when the direction is 0 and on `retPulse` when the direction is 1. Consecutive pulses are at least eight cycles apart.
- R4: A count of zero produces no pulse, and the count never wraps below zero.
- R5: A write on the same edge as a tick wins. The written value is loaded unchanged and no pulse follows that tick.
- R6: A write while a count is draining replaces the remainder and the direction. Only the new amount is emitted, in the new direction.
- R7: `rdData` changes only on an edge where `frameStart` is high. At that edge it captures the count and direction held just before the edge.
- R8: While `pwrDnN` or `genEn` is low, the count, direction and snapshot are forced to zero, writes are ignored and no pulse is emitted. These inputs do not disturb the prescaler.
- R9: `advPulse` and `retPulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrDnN | input | 1 | Power-down, active low; holds the block cleared |
| genEn | input | 1 | Clock generator enable; holds the block cleared when 0 |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word: bit 15 direction, bits 7:0 step count |
| frameStart | input | 1 | Frame-start marker; captures the readback snapshot |
| rdData | output | 16 | Snapshot of direction and remaining count |
| advPulse | output | 1 | One-cycle phase-advance step |
| retPulse | output | 1 | One-cycle phase-retard step |

## Verification
The embedded properties assume that `wrEn`, `frameStart`, `pwrDnN` and `genEn` are synchronous to `clk` and stable around each rising edge. They also assume `rstN` is the only asynchronous input. The bench drives every input on the falling edge, so all of them are settled at the rising edge that samples them. The bench counts edges from reset release to place each write exactly on, just after, or away from a prescaler tick. It sweeps counts 0 to 31 and 255 in both directions and compares the pulse totals with the written count.

// File: rtl/phs_pkg.sv
package phs_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic clear;    // block held cleared (reset, power-down, generator off)
    logic load;     // accepted write
    logic tick;     // prescaler tick
    logic capture;  // snapshot for readback
  } phsStrobe_t;

endpackage

// File: rtl/phs_control.sv
module phs_control
  import phs_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic       genEn,
  input  logic       wrEn,
  input  logic       frameStart,
  output phsStrobe_t strb
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic             clearNow;
  logic             tickNow;

  // Free-running divider; only the reset input restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign tickNow  = (preCnt == PRE_LAST);
  assign clearNow = !rstN || !pwrDnN || !genEn;

  always_comb begin
    strb.clear   = clearNow;
    strb.tick    = tickNow;
    strb.load    = wrEn && !clearNow;
    strb.capture = frameStart && !clearNow;
  end

  generate
    if (PRESCALE > 1) begin : g_tickChk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
        strb.tick |=> !strb.tick); // R3
    end
  endgenerate

  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrDnN || !genEn) |-> !strb.load); // R8

endmodule

// File: rtl/phs_datapath.sv
module phs_datapath
  import phs_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int MAG_W   = 8,
  parameter int DIR_POS = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  phsStrobe_t       strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             advPulse,
  output logic             retPulse
);

  logic [MAG_W-1:0] mag;
  logic             dir;
  logic             stepNow;
  logic [REG_W-1:0] liveWord;
  logic [REG_W-1:0] snap;

  assign stepNow = strb.tick && !strb.load && !strb.clear && (mag != '0);

  // Remaining count and direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mag <= '0;
      dir <= 1'b0;
    end else if (strb.clear) begin
      mag <= '0;
      dir <= 1'b0;
    end else if (strb.load) begin
      mag <= wrData[MAG_W-1:0];
      dir <= wrData[DIR_POS];
    end else if (stepNow) begin
      mag <= mag - MAG_W'(1);
    end
  end

  // Registered step pulses, steered by the direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      advPulse <= 1'b0;
      retPulse <= 1'b0;
    end else begin
      advPulse <= stepNow && !dir;
      retPulse <= stepNow && dir;
    end
  end

  // Readback word: reserved positions stay zero.
  always_comb begin
    liveWord = '0;
    liveWord[MAG_W-1:0] = mag;
    liveWord[DIR_POS] = dir;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap <= '0;
    end else if (strb.clear) begin
      snap <= '0;
    end else if (strb.capture) begin
      snap <= liveWord;
    end
  end

  assign rdData = snap;

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(advPulse && retPulse)); // R9
  AST_PULSE_DECREMENTS: assert property (@(posedge clk) disable iff (!rstN)
    (advPulse || retPulse) |-> (mag == $past(mag) - MAG_W'(1))); // R3
  AST_ADV_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    advPulse |-> !dir); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mag) == '0 && !$past(strb.load)) |-> (mag == '0)); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (mag == $past(wrData[MAG_W-1:0]) && !advPulse && !retPulse)); // R5
  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (mag == '0 && snap == '0 && !advPulse && !retPulse)); // R8
  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.clear) |=> $stable(snap)); // R7

endmodule

// File: rtl/phase_shift_ctrl.sv
module phase_shift_ctrl
  import phs_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int MAG_W    = 8,
  parameter int DIR_POS  = 15,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrDnN,
  input  logic             genEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             frameStart,
  output logic [REG_W-1:0] rdData,
  output logic             advPulse,
  output logic             retPulse
);

  phsStrobe_t strb;

  phs_control #(
    .PRESCALE(PRESCALE)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .pwrDnN    (pwrDnN),
    .genEn     (genEn),
    .wrEn      (wrEn),
    .frameStart(frameStart),
    .strb      (strb)
  );

  phs_datapath #(
    .REG_W  (REG_W),
    .MAG_W  (MAG_W),
    .DIR_POS(DIR_POS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdData  (rdData),
    .advPulse(advPulse),
    .retPulse(retPulse)
  );

endmodule

// File: tb/phase_shift_ctrl_bench.sv
module phase_shift_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrDnN = 1'b1;
  logic        genEn = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        frameStart = 1'b0;
  logic [15:0] rdData;
  logic        advPulse;
  logic        retPulse;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  int advCnt = 0;
  int retCnt = 0;
  int bothCnt = 0;
  int gapErr = 0;
  int lastPulse = -100;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_shift_ctrl u_phase_shift_ctrl (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .genEn(genEn),
    .wrEn(wrEn), .wrData(wrData), .frameStart(frameStart),
    .rdData(rdData), .advPulse(advPulse), .retPulse(retPulse)
  );

  // Edges since reset release; prescaler ticks fall on multiples of 8.
  always @(posedge clk) begin
    if (rstN) edgeCnt <= edgeCnt + 1;
    else edgeCnt <= 0;
  end

  // Pulse monitor
  always @(negedge clk) begin
    if (advPulse) advCnt <= advCnt + 1;
    if (retPulse) retCnt <= retCnt + 1;
    if (advPulse && retPulse) bothCnt <= bothCnt + 1;
    if (advPulse || retPulse) begin
      if (edgeCnt - lastPulse < 8) gapErr <= gapErr + 1;
      lastPulse <= edgeCnt;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Next edge will be the one whose count leaves remainder r modulo 8.
  task automatic alignTo(input int r);
    @(negedge clk);
    while (((edgeCnt + 1) % 8) != r) @(negedge clk);
  endtask

  task automatic writeWord(input logic [15:0] w);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic capture();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic runCase(input logic d, input int m);
    int a0, r0;
    alignTo(1);
    writeWord({d, 7'h7F, 8'(m)});
    #1;
    a0 = advCnt; r0 = retCnt;
    capture();
    chk("R2 readback after write", int'(rdData), int'({d, 7'b0, 8'(m)}));
    repeat (m * 8 + 16) @(negedge clk);
    #1;
    chk("R3 advance pulse total", advCnt - a0, d ? 0 : m);
    chk("R3 retard pulse total", retCnt - r0, d ? m : 0);
    capture();
    chk("R4 drained count stays zero", int'(rdData), int'({d, 15'b0}));
  endtask

  initial begin
    int a0, r0, e0;
    // R1: reset state, write during reset ignored
    repeat (3) @(negedge clk);
    writeWord(16'h8055);
    chk("R1 rdData in reset", int'(rdData), 0);
    chk("R1 no pulse in reset", int'(advPulse) + int'(retPulse), 0);
    rstN = 1'b1;
    capture();
    chk("R1 rdData after reset", int'(rdData), 0);

    // R2 R3 R4: sweep of counts in both directions
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 32; m++) runCase(d[0], m);
      runCase(d[0], 255);
    end

    // R5: write on a tick edge
    alignTo(1);
    writeWord(16'h000A);
    alignTo(0);
    writeWord(16'h8003);
    chk("R5 no pulse after tick-cycle write", int'(advPulse) + int'(retPulse), 0);
    #1;
    a0 = advCnt; r0 = retCnt;
    capture();
    chk("R5 loaded value intact", int'(rdData), 16'h8003);
    repeat (48) @(negedge clk);
    #1;
    chk("R5 retard total", retCnt - r0, 3);
    chk("R5 advance total", advCnt - a0, 0);

    // R6: overwrite mid-drain
    alignTo(1);
    writeWord(16'h00C8);
    repeat (40) @(negedge clk);
    alignTo(1);
    writeWord(16'h8004);
    #1;
    a0 = advCnt; r0 = retCnt;
    repeat (60) @(negedge clk);
    #1;
    chk("R6 new amount only", retCnt - r0, 4);
    chk("R6 old direction stopped", advCnt - a0, 0);

    // R7: snapshot holds between frame markers
    alignTo(1);
    writeWord(16'h0014);
    e0 = edgeCnt;
    capture();
    chk("R7 first snapshot", int'(rdData), 16'h0014);
    while (edgeCnt < e0 + 40) @(negedge clk);
    chk("R7 snapshot held", int'(rdData), 16'h0014);
    capture();
    chk("R7 second snapshot", int'(rdData), 16'h000F);
    repeat (200) @(negedge clk);

    // R8: power-down clears and blocks writes
    alignTo(1);
    writeWord(16'h8032);
    repeat (20) @(negedge clk);
    pwrDnN = 1'b0;
    @(negedge clk);
    #1;
    a0 = advCnt; r0 = retCnt;
    writeWord(16'h0009);
    capture();
    repeat (20) @(negedge clk);
    #1;
    chk("R8 no pulse in power-down", (advCnt - a0) + (retCnt - r0), 0);
    chk("R8 readback zero in power-down", int'(rdData), 0);
    pwrDnN = 1'b1;
    capture();
    chk("R8 cleared after power-down", int'(rdData), 0);
    repeat (40) @(negedge clk);
    #1;
    chk("R8 nothing left after power-down", (advCnt - a0) + (retCnt - r0), 0);

    // R8: generator disable
    alignTo(1);
    writeWord(16'h0028);
    repeat (20) @(negedge clk);
    genEn = 1'b0;
    @(negedge clk);
    #1;
    a0 = advCnt; r0 = retCnt;
    writeWord(16'h8007);
    repeat (30) @(negedge clk);
    genEn = 1'b1;
    capture();
    chk("R8 cleared after disable", int'(rdData), 0);
    repeat (40) @(negedge clk);
    #1;
    chk("R8 no pulse around disable", (advCnt - a0) + (retCnt - r0), 0);

    // R8: prescaler undisturbed; tick still on multiples of 8
    alignTo(1);
    writeWord(16'h0001);
    #1;
    a0 = advCnt;
    e0 = edgeCnt;
    while (advCnt == a0 && edgeCnt < e0 + 20) @(negedge clk);
    chk("R8 prescaler phase kept", lastPulse % 8, 0);

    chk("R3 pulse spacing", gapErr, 0);
    chk("R9 both pulses together", bothCnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule